// File: doc/BRIEF.md
# Queue Controller for an External Single-Port SRAM

This block is the control half of a first-in first-out queue whose storage is a separate single-port SRAM. It owns a read pointer, a write pointer and an occupancy count. Because the SRAM has one address bus, each accepted request latches the address of exactly one of the pointers and runs a single memory operation at a time. A read is one cycle with the output enable raised. A write is three cycles: setup, strobe and hold. Data bytes pass straight between the ports and the SRAM pins.

A request is a one-cycle pulse on `push_req` or `pop_req`, sampled while `busy` is low. When both arrive together and the queue holds data, the read runs first and the write follows straight after it. Status outputs give the empty, full and half-full conditions, all taken from the registered occupancy count. The default address width of 15 bits gives 32768 entries.

Top module: `sqc_top`

## Requirements
- R1: After reset `empty` is 1. `full`, `half_full`, `busy`, `pop_valid`, `sram_ce`, `sram_oe` and `sram_we` are all 0.
- R2: Pop requests return data in the order it was pushed.
- R3: A push request while `full` is 1 is ignored. No write strobe occurs and the stored contents and flags stay unchanged.
- R4: A pop request while `empty` is 1 is ignored. `pop_valid` stays 0 and `empty` stays 1.
- R5: When both requests arrive in the same idle cycle and the queue is not empty, the read is performed before the write.
- R6: A write addresses the SRAM at the write pointer and a read at the read pointer. Each pointer advances by one per accepted operation and wraps modulo 2^ADDR_W.
- R7: `full` is 1 exactly when the occupancy equals 2^ADDR_W.
- R8: `half_full` is 1 exactly when the occupancy is at least 2^(ADDR_W-1).
- R9: A write raises `sram_we` for exactly one cycle. It is preceded by a setup cycle and followed by a hold cycle. In both of those cycles `sram_ce` is 1, `sram_we` is 0, and the address and write data match the strobe cycle.
- R10: Requests that arrive while `busy` is 1 are ignored.
- R11: A read drives `sram_oe`, `sram_ce` and `pop_valid` high for one cycle, with `pop_data` equal to the SRAM read data. `sram_oe` and `sram_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Enqueue request pulse |
| push_data | input | DATA_W | Data to enqueue |
| pop_req | input | 1 | Dequeue request pulse |
| pop_valid | output | 1 | Read cycle in progress; pop_data is valid |
| pop_data | output | DATA_W | Dequeued data |
| busy | output | 1 | An SRAM operation is in progress |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_ce | output | 1 | SRAM chip enable, active high |
| sram_oe | output | 1 | SRAM output enable, active high |
| sram_we | output | 1 | SRAM write strobe, active high |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| half_full | output | 1 | Occupancy at least half the depth |

## Verification
The hardest situation to reach is the queue sitting exactly at full while a simultaneous push and pop arrive. That case chains a read, a pending write and a wrapped write pointer. With the full 15-bit width it takes tens of thousands of writes to get there. The bench therefore builds the controller with a 5-bit address, fills it with directed pushes and then issues the combined request and further pushes at the boundary. Random phases that alternate between push-heavy and pop-heavy drive the count across the half and full thresholds many times. Extra requests are injected while operations are in flight to exercise the ignored-while-busy path.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WSET  = 3'd2,
        ST_WPUL  = 3'd3,
        ST_WHLD  = 3'd4
    } sqc_state_e;
endpackage

// File: rtl/sqc_ptr.sv
module sqc_ptr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] ptr
);
    logic [W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = ptr_q + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/sqc_level.sv
module sqc_level #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W:0] count,
    output logic            full,
    output logic            empty,
    output logic            half_full
);
    localparam logic [ADDR_W:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] HALF_LVL = {2'b01, {(ADDR_W-1){1'b0}}};

    assign full      = (count == FULL_LVL);
    assign empty     = (count == '0);
    assign half_full = (count >= HALF_LVL);
endmodule

// File: rtl/sqc_top.sv
module sqc_top #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              busy,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_ce,
    output logic              sram_oe,
    output logic              sram_we,
    output logic              full,
    output logic              empty,
    output logic              half_full
);
    import sqc_pkg::*;

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

    typedef struct packed {
        sqc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pend;
        logic [CNT_W-1:0]  count;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic head_adv, tail_adv;
    logic [ADDR_W-1:0] head_ptr, tail_ptr;

    sqc_ptr #(.W(ADDR_W)) i_head (
        .clk(clk), .rst_n(rst_n), .adv(head_adv), .ptr(head_ptr)
    );

    sqc_ptr #(.W(ADDR_W)) i_tail (
        .clk(clk), .rst_n(rst_n), .adv(tail_adv), .ptr(tail_ptr)
    );

    sqc_level #(.ADDR_W(ADDR_W)) i_level (
        .count(r_q.count), .full(full), .empty(empty), .half_full(half_full)
    );

    always_comb begin
        r_d      = r_q;
        head_adv = 1'b0;
        tail_adv = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (pop_req && !empty) begin
                    r_d.state = ST_READ;
                    r_d.addr  = head_ptr;
                    r_d.count = r_q.count - ONE;
                    head_adv  = 1'b1;
                    if (push_req) begin
                        r_d.pend = 1'b1;
                        r_d.data = push_data;
                    end
                end else if (push_req && !full) begin
                    r_d.state = ST_WSET;
                    r_d.addr  = tail_ptr;
                    r_d.data  = push_data;
                    r_d.count = r_q.count + ONE;
                    tail_adv  = 1'b1;
                end
            end
            ST_READ: begin
                r_d.state = ST_IDLE;
                if (r_q.pend) begin
                    r_d.pend = 1'b0;
                    if (!full) begin
                        r_d.state = ST_WSET;
                        r_d.addr  = tail_ptr;
                        r_d.count = r_q.count + ONE;
                        tail_adv  = 1'b1;
                    end
                end
            end
            ST_WSET: r_d.state = ST_WPUL;
            ST_WPUL: r_d.state = ST_WHLD;
            ST_WHLD: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.data  <= '0;
            r_q.pend  <= 1'b0;
            r_q.count <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign sram_ce    = busy;
    assign sram_oe    = (r_q.state == ST_READ);
    assign sram_we    = (r_q.state == ST_WPUL);
    assign sram_addr  = r_q.addr;
    assign sram_wdata = r_q.data;
    assign pop_valid  = sram_oe;
    assign pop_data   = sram_rdata;
endmodule

// File: rtl/sqc_checker.sv
module sqc_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pop_req,
    input logic              pop_valid,
    input logic              busy,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic              sram_ce,
    input logic              sram_oe,
    input logic              sram_we,
    input logic              full,
    input logic              empty,
    input logic              half_full
);
    assert_we_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> !sram_we);

    assert_we_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we) |-> ($past(sram_ce) && $stable(sram_addr) && $stable(sram_wdata)));

    assert_we_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we) |-> (sram_ce && $stable(sram_addr) && $stable(sram_wdata)));

    assert_rw_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_oe && sram_we));

    assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (sram_oe && sram_ce));

    assert_full_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && !empty));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req && !busy) |=> (full && !busy));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req && !busy) |=> (!pop_valid && empty));
endmodule

bind sqc_top sqc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sqc_checker (.*);

// File: tb/test_sqc_top.sv
module test_sqc_top;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_valid, busy, sram_ce, sram_oe, sram_we, full, empty, half_full;
    logic [DW-1:0] pop_data, sram_wdata, sram_rdata;
    logic [AW-1:0] sram_addr;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mq  [DEPTH];
    int hd = 0, tl = 0, cnt = 0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    sqc_top #(.ADDR_W(AW), .DATA_W(DW)) i_sqc_top (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data), .busy(busy),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_ce(sram_ce), .sram_oe(sram_oe), .sram_we(sram_we),
        .full(full), .empty(empty), .half_full(half_full)
    );

    always @(posedge clk) if (sram_ce && sram_we) mem[sram_addr] <= sram_wdata;
    assign sram_rdata = sram_oe ? mem[sram_addr] : '0;

    function automatic bit exp_full(int c);  return c == DEPTH;      endfunction
    function automatic bit exp_half(int c);  return c >= DEPTH / 2;  endfunction
    function automatic bit exp_empty(int c); return c == 0;          endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic op(input bit p, input bit q, input logic [DW-1:0] d, input bit inject);
        bit exp_rd, exp_wr;
        int erd_addr = 0, ewr_addr = 0;
        logic [DW-1:0] erd_data = '0;
        int rd_seen = 0, wr_seen = 0, rd_t = -1, wr_t = -1, t = 0;
        int rd_addr = 0, wr_addr = 0;
        logic [DW-1:0] rd_got = '0, wr_got = '0;
        exp_rd = q && (cnt > 0);
        if (exp_rd) begin
            erd_addr = hd; erd_data = mq[hd];
            hd = (hd + 1) % DEPTH; cnt--;
        end
        exp_wr = p && (cnt < DEPTH);
        if (exp_wr) begin
            ewr_addr = tl; mq[tl] = d;
            tl = (tl + 1) % DEPTH; cnt++;
        end
        push_req = p; pop_req = q; push_data = d;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        while (busy) begin
            if (inject && t == 0) begin
                push_req = 1'b1; pop_req = 1'b1; push_data = ~d;
            end else begin
                push_req = 1'b0; pop_req = 1'b0;
            end
            if (pop_valid) begin rd_seen++; rd_t = t; rd_got = pop_data; rd_addr = int'(sram_addr); end
            if (sram_we)   begin wr_seen++; wr_t = t; wr_got = sram_wdata; wr_addr = int'(sram_addr); end
            t++;
            @(negedge clk);
        end
        push_req = 1'b0; pop_req = 1'b0;
        if (exp_rd) begin
            chk(rd_seen == 1, "R11 read cycles", rd_seen, 1);
            chk(rd_got == erd_data, "R2 pop data", int'(rd_got), int'(erd_data));
            chk(rd_addr == erd_addr, "R6 read address", rd_addr, erd_addr);
        end else begin
            chk(rd_seen == 0, "R4 ignored pop", rd_seen, 0);
        end
        if (exp_wr) begin
            chk(wr_seen == 1, "R9 write strobes", wr_seen, 1);
            chk(wr_addr == ewr_addr, "R6 write address", wr_addr, ewr_addr);
            chk(wr_got == d, "R6 write data", int'(wr_got), int'(d));
        end else begin
            chk(wr_seen == 0, "R3 ignored push", wr_seen, 0);
        end
        if (exp_rd && exp_wr) chk(rd_t < wr_t, "R5 read before write", rd_t, wr_t);
        chk(full == exp_full(cnt), "R7 full", int'(full), int'(exp_full(cnt)));
        chk(half_full == exp_half(cnt), "R8 half_full", int'(half_full), int'(exp_half(cnt)));
        chk(empty == exp_empty(cnt), "R4 empty", int'(empty), int'(exp_empty(cnt)));
        if (inject) begin
            @(negedge clk);
            chk(!busy, "R10 busy request ignored", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        chk(empty && !full && !half_full, "R1 reset flags", {29'd0, empty, full, half_full}, 4);
        chk(!busy && !pop_valid && !sram_ce && !sram_oe && !sram_we, "R1 reset strobes",
            {27'd0, busy, pop_valid, sram_ce, sram_oe, sram_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: pop on empty
        op(1'b0, 1'b1, 8'h00, 1'b0);
        // R5: both on empty -> write only
        op(1'b1, 1'b1, 8'h11, 1'b0);
        for (int i = 0; i < 5; i++) op(1'b1, 1'b0, 8'hA0 + 8'(i), 1'b0);
        // R5: both with data present
        op(1'b1, 1'b1, 8'h5C, 1'b0);
        for (int i = 0; i < 7; i++) op(1'b0, 1'b1, 8'h00, 1'b0);
        // fill to full across the R8 threshold
        for (int i = 0; i < DEPTH + 2; i++) op(1'b1, 1'b0, 8'(i * 7 + 3), 1'b0);
        // R3: push on full, then both on full
        op(1'b1, 1'b0, 8'hEE, 1'b0);
        op(1'b1, 1'b1, 8'h77, 1'b0);
        op(1'b1, 1'b0, 8'hEF, 1'b0);
        // R10: inject while busy
        op(1'b0, 1'b1, 8'h00, 1'b1);
        op(1'b1, 1'b0, 8'h42, 1'b1);
        for (int i = 0; i < DEPTH + 2; i++) op(1'b0, 1'b1, 8'h00, 1'b0);
        // random phases
        for (int i = 0; i < 3000; i++) begin
            int bias;
            bias = ((i / 150) % 2 == 0) ? 75 : 25;
            op(($urandom % 100) < bias, ($urandom % 100) < (100 - bias),
               8'($urandom), ($urandom % 8) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule